// File: doc/BRIEF.md
# Receive Ring Buffer Writer

This block takes a received Ethernet frame as a byte stream and lays it into a circular buffer in host memory through a byte-wide write port. Each frame becomes a record. The record starts with a four-byte header that holds a status word and the frame length. The frame bytes follow the header, and the next record begins at the next four-byte boundary. When frame data runs past the end of the buffer, it continues from the start of the buffer.

The block keeps its own write offset. The host owns a read pointer register, which it writes after it consumes records. That register is biased: it holds the true read offset minus 16. The block compares the two offsets to report an empty buffer and to refuse frames that would overwrite unread records.

Until a record is complete, its length field reads 0xFFF0. The block writes this busy marker into the next record slot as soon as the previous record is finished. The real header is written only after the last data byte has been stored.

Preconditions on use:
- The source leaves at least 8 idle cycles between an end-of-frame byte and the next start-of-frame.
- The host only writes read pointer values that give four-byte-aligned offsets.

Top module: `rx_ring_writer`

## Requirements
- R1: After reset, `buf_empty` is 1, `wr_offset` is 0 and `rdptr_q` reads 0xFFF0. Within two cycles of reset, the busy marker 0xF0, 0xFF is stored at buffer offsets 2 and 3.
- R2: A stored frame's bytes are written at `cfg_base` + (record offset + 4 + i) for byte i, in arrival order.
- R3: Header bytes 0 and 1 hold the status word and bytes 2 and 3 hold the length L, both little-endian. L is the number of bytes in the frame, CRC included.
- R4: The status word has these bits, and all other bits are 0. `rx_err` and `rx_match` are sampled with the end-of-frame byte.
  - Bit 0 is 1 when `rx_err` is all zero.
  - Bits 1 to 5 equal `rx_err[0..4]`: alignment, CRC, long, runt and symbol error.
  - Bits 13, 14 and 15 equal `rx_match[0..2]`: broadcast, physical match and multicast.
- R5: While a frame's data is being written, its record's length field reads 0xFFF0. During that time `wr_offset` does not change and `buf_empty` stays as it was.
- R6: After a stored frame, the write offset becomes (record offset + 4 + L) rounded up to a multiple of 4, modulo the buffer length. `cfg_size_sel` values 0, 1, 2 and 3 give buffer lengths of 1, 2, 4 and 8 times 2^MIN_LOG2 bytes.
- R7: Data that passes the last buffer offset continues at offset 0.
- R8: The read offset is (`rdptr_q` + 16) modulo the buffer length. `buf_empty` is 1 exactly when the read offset equals the write offset.
- R9: Let free = length - ((write - read) mod length). A frame is stored only if L + 8 <= free. Otherwise it is dropped, `irq_overflow` pulses for one cycle, `wr_offset` is unchanged and the pending busy marker is untouched.
- R10: For each stored frame, exactly one of these pulses rises for one cycle, in the cycle in which `wr_offset` takes its new value: `irq_rx_ok` if status bit 0 is set, `irq_rx_err` otherwise.
- R11: A one-byte frame, with start and end flags on the same byte, is stored with L = 1 and an eight-byte record.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_base | input | ADDR_W | Byte address of buffer offset 0 |
| cfg_size_sel | input | 2 | Buffer length select |
| rdptr_we | input | 1 | Write strobe for the host read pointer |
| rdptr_wdata | input | 16 | New host read pointer (read offset minus 16) |
| rdptr_q | output | 16 | Current host read pointer |
| wr_offset | output | 16 | Offset of the next record |
| buf_empty | output | 1 | No unread record remains |
| rx_valid | input | 1 | Byte present on rx_data |
| rx_sof | input | 1 | First byte of a frame |
| rx_eof | input | 1 | Last byte of a frame |
| rx_data | input | 8 | Frame byte |
| rx_err | input | 5 | Error flags: alignment, CRC, long, runt, symbol (bit 0 first) |
| rx_match | input | 3 | Address class: broadcast, physical, multicast (bit 0 first) |
| mem_we | output | 1 | Memory byte write strobe |
| mem_addr | output | ADDR_W | Memory byte address |
| mem_wdata | output | 8 | Memory byte data |
| irq_rx_ok | output | 1 | Pulse: good frame stored |
| irq_rx_err | output | 1 | Pulse: errored frame stored |
| irq_overflow | output | 1 | Pulse: frame dropped for lack of space |

## Verification
The bench builds the block with MIN_LOG2 = 6, so the smallest buffer is 64 bytes and the largest is 512 bytes. With a 64-byte buffer, a handful of short frames is enough to reach a record that straddles the buffer end, a frame that fits with no byte to spare, and a frame that is one byte too long. A 16-bit address and a nonzero base exercise the address offset. A reset with size select 3 shows a write offset that runs beyond 64 bytes.

// File: rtl/rxrb_pkg.sv
package rxrb_pkg;

    // Length field value while a record is still being filled
    localparam logic [15:0] BUSY_LEN = 16'hFFF0;
    // Host pointer bias and its reset value (read offset 0)
    localparam logic [15:0] HOST_BIAS      = 16'd16;
    localparam logic [15:0] HOST_PTR_RESET = 16'hFFF0;
    // Header bytes plus alignment reserve used by the space test
    localparam int HDR_BYTES = 4;
    localparam int SPACE_RESERVE = 8;

    typedef enum logic [2:0] {
        ST_MARK0,
        ST_MARK1,
        ST_IDLE,
        ST_DATA,
        ST_DROP,
        ST_HDR
    } seq_state_e;

    typedef struct packed {
        logic [15:0] length;
        logic [15:0] status;
    } rec_hdr_t;

    function automatic logic [15:0] build_status(input logic [4:0] err,
                                                 input logic [2:0] match);
        return {match[2], match[1], match[0], 7'b0, err, ~|err};
    endfunction

endpackage

// File: rtl/rxrb_ptrs.sv
module rxrb_ptrs
    import rxrb_pkg::*;
#(
    parameter int MIN_LOG2 = 13,
    localparam int OFF_W = MIN_LOG2 + 3,
    localparam int CW = OFF_W + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       size_sel,
    input  logic             rdptr_we,
    input  logic [15:0]      rdptr_wdata,
    input  logic             commit,
    input  logic [OFF_W-1:0] commit_off,
    output logic [15:0]      rdptr_q,
    output logic [OFF_W-1:0] wr_off,
    output logic [OFF_W-1:0] len_mask,
    output logic [CW-1:0]    free_bytes,
    output logic             empty
);

    logic [CW-1:0]    buf_len;
    logic [15:0]      rd_raw;
    logic [OFF_W-1:0] rd_off;
    logic [OFF_W-1:0] used;

    assign buf_len  = CW'(1 << MIN_LOG2) << size_sel;
    assign len_mask = buf_len[OFF_W-1:0] - OFF_W'(1);

    // Host pointer carries a -16 bias
    assign rd_raw = rdptr_q + HOST_BIAS;
    assign rd_off = rd_raw[OFF_W-1:0] & len_mask;

    assign used       = (wr_off - rd_off) & len_mask;
    assign free_bytes = buf_len - {1'b0, used};
    assign empty      = (wr_off == rd_off);

    always_ff @(posedge clk) begin
        if (rst) begin
            rdptr_q <= HOST_PTR_RESET;
        end else if (rdptr_we) begin
            rdptr_q <= rdptr_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_off <= '0;
        end else if (commit) begin
            wr_off <= commit_off;
        end
    end

endmodule

// File: rtl/rxrb_seq.sv
module rxrb_seq
    import rxrb_pkg::*;
#(
    parameter int MIN_LOG2 = 13,
    parameter int ADDR_W = 32,
    localparam int OFF_W = MIN_LOG2 + 3,
    localparam int CW = OFF_W + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] base,
    input  logic [OFF_W-1:0]  wr_off,
    input  logic [OFF_W-1:0]  len_mask,
    input  logic [CW-1:0]     free_bytes,
    input  logic              rx_valid,
    input  logic              rx_sof,
    input  logic              rx_eof,
    input  logic [7:0]        rx_data,
    input  logic [4:0]        rx_err,
    input  logic [2:0]        rx_match,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata,
    output logic              commit,
    output logic [OFF_W-1:0]  commit_off,
    output logic              pulse_ok,
    output logic              pulse_err,
    output logic              pulse_ovf
);

    seq_state_e       state;
    logic [CW-1:0]    cnt;
    logic [CW-1:0]    space_q;
    rec_hdr_t         hdr_q;
    logic [1:0]       hidx;

    logic             take;
    logic [CW-1:0]    cnt_eff;
    logic [CW-1:0]    space_eff;
    logic             fits;
    logic [OFF_W-1:0] data_off;
    logic [OFF_W-1:0] wr_off_off;
    logic [OFF_W-1:0] rec_end;
    logic [31:0]      hdr_bytes;
    logic [15:0]      new_len;

    // A byte is taken at frame start from idle, or any byte mid-frame
    assign take      = rx_valid && ((state == ST_IDLE && rx_sof) || state == ST_DATA);
    assign cnt_eff   = (state == ST_IDLE) ? '0 : cnt;
    assign space_eff = (state == ST_IDLE) ? free_bytes : space_q;
    assign fits      = (cnt_eff + CW'(SPACE_RESERVE + 1)) <= space_eff;
    assign data_off  = (wr_off + OFF_W'(HDR_BYTES) + cnt_eff[OFF_W-1:0]) & len_mask;
    assign new_len   = 16'(cnt_eff + CW'(1));

    assign hdr_bytes = hdr_q;
    assign rec_end   = wr_off + OFF_W'(HDR_BYTES) + hdr_q.length[OFF_W-1:0] + OFF_W'(3);
    assign commit_off = {rec_end[OFF_W-1:2], 2'b00} & len_mask;
    assign commit    = (state == ST_HDR) && (hidx == 2'd3);

    always_comb begin
        mem_we     = 1'b0;
        wr_off_off = '0;
        mem_wdata  = '0;
        unique case (state)
            ST_MARK0: begin
                mem_we     = 1'b1;
                wr_off_off = (wr_off + OFF_W'(2)) & len_mask;
                mem_wdata  = BUSY_LEN[7:0];
            end
            ST_MARK1: begin
                mem_we     = 1'b1;
                wr_off_off = (wr_off + OFF_W'(3)) & len_mask;
                mem_wdata  = BUSY_LEN[15:8];
            end
            ST_IDLE, ST_DATA: begin
                if (take && fits) begin
                    mem_we     = 1'b1;
                    wr_off_off = data_off;
                    mem_wdata  = rx_data;
                end
            end
            ST_HDR: begin
                mem_we     = 1'b1;
                wr_off_off = (wr_off + OFF_W'(hidx)) & len_mask;
                mem_wdata  = hdr_bytes[8*hidx +: 8];
            end
            default: begin
                mem_we = 1'b0;
            end
        endcase
    end

    assign mem_addr = base + ADDR_W'(wr_off_off);

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_MARK0;
            cnt       <= '0;
            space_q   <= '0;
            hdr_q     <= '0;
            hidx      <= '0;
            pulse_ok  <= 1'b0;
            pulse_err <= 1'b0;
            pulse_ovf <= 1'b0;
        end else begin
            pulse_ok  <= 1'b0;
            pulse_err <= 1'b0;
            pulse_ovf <= 1'b0;
            unique case (state)
                ST_MARK0: state <= ST_MARK1;
                ST_MARK1: state <= ST_IDLE;
                ST_IDLE, ST_DATA: begin
                    if (take) begin
                        if (state == ST_IDLE) begin
                            space_q <= free_bytes;
                        end
                        if (fits) begin
                            cnt <= cnt_eff + CW'(1);
                            if (rx_eof) begin
                                hdr_q.status <= build_status(rx_err, rx_match);
                                hdr_q.length <= new_len;
                                hidx         <= '0;
                                state        <= ST_HDR;
                            end else begin
                                state <= ST_DATA;
                            end
                        end else if (rx_eof) begin
                            pulse_ovf <= 1'b1;
                            state     <= ST_IDLE;
                        end else begin
                            state <= ST_DROP;
                        end
                    end
                end
                ST_DROP: begin
                    if (rx_valid && rx_eof) begin
                        pulse_ovf <= 1'b1;
                        state     <= ST_IDLE;
                    end
                end
                ST_HDR: begin
                    hidx <= hidx + 2'd1;
                    if (hidx == 2'd3) begin
                        pulse_ok  <= hdr_q.status[0];
                        pulse_err <= ~hdr_q.status[0];
                        state     <= ST_MARK0;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/rx_ring_writer.sv
module rx_ring_writer
    import rxrb_pkg::*;
#(
    parameter int MIN_LOG2 = 13,
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] cfg_base,
    input  logic [1:0]        cfg_size_sel,
    input  logic              rdptr_we,
    input  logic [15:0]       rdptr_wdata,
    output logic [15:0]       rdptr_q,
    output logic [15:0]       wr_offset,
    output logic              buf_empty,
    input  logic              rx_valid,
    input  logic              rx_sof,
    input  logic              rx_eof,
    input  logic [7:0]        rx_data,
    input  logic [4:0]        rx_err,
    input  logic [2:0]        rx_match,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata,
    output logic              irq_rx_ok,
    output logic              irq_rx_err,
    output logic              irq_overflow
);

    // Offsets reach 2^(MIN_LOG2+3); the 16-bit pointer limits MIN_LOG2 to 13
    localparam int OFF_W = MIN_LOG2 + 3;
    localparam int CW = OFF_W + 1;

    logic [OFF_W-1:0] wr_off;
    logic [OFF_W-1:0] len_mask;
    logic [CW-1:0]    free_bytes;
    logic             commit;
    logic [OFF_W-1:0] commit_off;

    rxrb_ptrs #(.MIN_LOG2(MIN_LOG2)) u_ptrs (
        .clk        (clk),
        .rst        (rst),
        .size_sel   (cfg_size_sel),
        .rdptr_we   (rdptr_we),
        .rdptr_wdata(rdptr_wdata),
        .commit     (commit),
        .commit_off (commit_off),
        .rdptr_q    (rdptr_q),
        .wr_off     (wr_off),
        .len_mask   (len_mask),
        .free_bytes (free_bytes),
        .empty      (buf_empty)
    );

    rxrb_seq #(.MIN_LOG2(MIN_LOG2), .ADDR_W(ADDR_W)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .base      (cfg_base),
        .wr_off    (wr_off),
        .len_mask  (len_mask),
        .free_bytes(free_bytes),
        .rx_valid  (rx_valid),
        .rx_sof    (rx_sof),
        .rx_eof    (rx_eof),
        .rx_data   (rx_data),
        .rx_err    (rx_err),
        .rx_match  (rx_match),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .commit    (commit),
        .commit_off(commit_off),
        .pulse_ok  (irq_rx_ok),
        .pulse_err (irq_rx_err),
        .pulse_ovf (irq_overflow)
    );

    assign wr_offset = 16'(wr_off);

endmodule

// File: rtl/rxrb_chk.sv
module rxrb_chk #(
    parameter int MIN_LOG2 = 13,
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] cfg_base,
    input logic [1:0]        cfg_size_sel,
    input logic [15:0]       wr_offset,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              irq_rx_ok,
    input logic              irq_rx_err,
    input logic              irq_overflow
);

    logic [ADDR_W-1:0] chk_len;
    assign chk_len = ADDR_W'(1 << MIN_LOG2) << cfg_size_sel;

    // R10: one outcome pulse per stored frame
    a_r10_ok_err_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(irq_rx_ok && irq_rx_err));

    // R10: the write offset moves only together with a stored-frame pulse
    a_r10_wr_moves_with_pulse: assert property (@(posedge clk) disable iff (rst)
        !$stable(wr_offset) |-> (irq_rx_ok || irq_rx_err));

    // R9: a dropped frame leaves the write offset where it was
    a_r9_drop_keeps_wr: assert property (@(posedge clk) disable iff (rst)
        irq_overflow |-> ($stable(wr_offset) && !irq_rx_ok && !irq_rx_err));

    // R6: records start on four-byte boundaries
    a_r6_wr_aligned: assert property (@(posedge clk) disable iff (rst)
        wr_offset[1:0] == 2'b00);

    // R7: every write lands inside the selected buffer
    a_r7_addr_in_buffer: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> ((mem_addr - cfg_base) < chk_len));

endmodule

bind rx_ring_writer rxrb_chk #(.MIN_LOG2(MIN_LOG2), .ADDR_W(ADDR_W)) u_rxrb_chk (
    .clk         (clk),
    .rst         (rst),
    .cfg_base    (cfg_base),
    .cfg_size_sel(cfg_size_sel),
    .wr_offset   (wr_offset),
    .mem_we      (mem_we),
    .mem_addr    (mem_addr),
    .irq_rx_ok   (irq_rx_ok),
    .irq_rx_err  (irq_rx_err),
    .irq_overflow(irq_overflow)
);

// File: tb/test_rx_ring_writer.sv
`timescale 1ns/1ps
module test_rx_ring_writer;

    localparam int MIN_LOG2 = 6;
    localparam int ADDR_W = 16;
    localparam logic [15:0] BASE = 16'h1000;
    localparam int MEM_SZ = 512;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [ADDR_W-1:0] cfg_base = BASE;
    logic [1:0]        cfg_size_sel = 2'd0;
    logic              rdptr_we = 1'b0;
    logic [15:0]       rdptr_wdata = '0;
    logic [15:0]       rdptr_q;
    logic [15:0]       wr_offset;
    logic              buf_empty;
    logic              rx_valid = 1'b0;
    logic              rx_sof = 1'b0;
    logic              rx_eof = 1'b0;
    logic [7:0]        rx_data = '0;
    logic [4:0]        rx_err = '0;
    logic [2:0]        rx_match = '0;
    logic              mem_we;
    logic [ADDR_W-1:0] mem_addr;
    logic [7:0]        mem_wdata;
    logic              irq_rx_ok;
    logic              irq_rx_err;
    logic              irq_overflow;

    always #2 clk = ~clk;

    rx_ring_writer #(.MIN_LOG2(MIN_LOG2), .ADDR_W(ADDR_W)) i_rx_ring_writer (
        .clk(clk), .rst(rst), .cfg_base(cfg_base), .cfg_size_sel(cfg_size_sel),
        .rdptr_we(rdptr_we), .rdptr_wdata(rdptr_wdata), .rdptr_q(rdptr_q),
        .wr_offset(wr_offset), .buf_empty(buf_empty),
        .rx_valid(rx_valid), .rx_sof(rx_sof), .rx_eof(rx_eof), .rx_data(rx_data),
        .rx_err(rx_err), .rx_match(rx_match),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .irq_rx_ok(irq_rx_ok), .irq_rx_err(irq_rx_err), .irq_overflow(irq_overflow)
    );

    logic [7:0] mem [MEM_SZ];
    int n_ok = 0, n_err = 0, n_ovf = 0;
    int checks = 0, fails = 0;
    int blen = 64;
    bit finished = 0;

    always @(negedge clk) begin
        if (!rst) begin
            if (mem_we) mem[int'(mem_addr - BASE) % MEM_SZ] = mem_wdata;
            if (irq_rx_ok) n_ok++;
            if (irq_rx_err) n_err++;
            if (irq_overflow) n_ovf++;
        end
    end

    task automatic check(input string tag, input int got, input int exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
        end
    endtask

    function automatic int exp_status(input logic [4:0] err, input logic [2:0] m);
        int s = 0;
        if (err == 0) s |= 1;
        for (int b = 0; b < 5; b++) if (err[b]) s |= (1 << (b + 1));
        for (int b = 0; b < 3; b++) if (m[b]) s |= (1 << (13 + b));
        return s;
    endfunction

    task automatic do_reset(input logic [1:0] sel);
        @(posedge clk); #1;
        rst = 1'b1;
        cfg_size_sel = sel;
        blen = 64 << sel;
        for (int i = 0; i < MEM_SZ; i++) mem[i] = 8'h00;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        repeat (4) @(posedge clk);
    endtask

    task automatic write_rdptr(input logic [15:0] v);
        @(posedge clk); #1;
        rdptr_we = 1'b1; rdptr_wdata = v;
        @(posedge clk); #1;
        rdptr_we = 1'b0;
        @(negedge clk);
    endtask

    // Streams one frame; mid_off >= 0 checks the busy marker while data flows
    task automatic send(input int len, input logic [7:0] seed, input logic [4:0] err,
                        input logic [2:0] m, input int mid_off);
        for (int i = 0; i < len; i++) begin
            @(posedge clk); #1;
            rx_valid = 1'b1;
            rx_sof = (i == 0);
            rx_eof = (i == len - 1);
            rx_data = seed + 8'(i);
            rx_err = (i == len - 1) ? err : 5'b0;
            rx_match = (i == len - 1) ? m : 3'b0;
            if (mid_off >= 0 && i == 3) begin
                @(negedge clk);
                check("R5 busy low", mem[(mid_off + 2) % blen], 8'hF0);
                check("R5 busy high", mem[(mid_off + 3) % blen], 8'hFF);
                check("R5 wr held", wr_offset, mid_off);
                check("R5 empty held", buf_empty, 1);
            end
        end
        @(posedge clk); #1;
        rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0; rx_err = '0; rx_match = '0;
        repeat (10) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check_record(input string tag, input int off, input int len,
                                input logic [7:0] seed, input int status);
        int bad = 0;
        check({tag, " R3 status"}, {mem[(off + 1) % blen], mem[off % blen]}, status);
        check({tag, " R3 length"}, {mem[(off + 3) % blen], mem[(off + 2) % blen]}, len);
        for (int i = 0; i < len; i++)
            if (mem[(off + 4 + i) % blen] !== seed + 8'(i)) bad++;
        check({tag, " R2 data bytes wrong"}, bad, 0);
    endtask

    task automatic t_reset();
        do_reset(2'd0);
        check("R1 empty", buf_empty, 1);
        check("R1 wr", wr_offset, 0);
        check("R1 rdptr", rdptr_q, 16'hFFF0);
        check("R1 marker lo", mem[2], 8'hF0);
        check("R1 marker hi", mem[3], 8'hFF);
    endtask

    task automatic t_good_frame();
        int ok0 = n_ok;
        send(10, 8'h10, 5'b0, 3'b010, -1);
        check_record("R4 good", 0, 10, 8'h10, 16'h4001);
        check("R6 wr after 10", wr_offset, 16);
        check("R10 ok pulse", n_ok - ok0, 1);
        check("R8 not empty", buf_empty, 0);
    endtask

    task automatic t_err_frame();
        int e0 = n_err;
        send(20, 8'h40, 5'b00010, 3'b001, -1);
        check_record("R4 crc", 16, 20, 8'h40, exp_status(5'b00010, 3'b001));
        check("R6 wr after 20", wr_offset, 40);
        check("R10 err pulse", n_err - e0, 1);
    endtask

    task automatic t_overflow();
        int o0 = n_ovf, k0 = n_ok + n_err;
        send(20, 8'h70, 5'b0, 3'b0, -1);   // needs 28, only 24 free
        check("R9 overflow pulse", n_ovf - o0, 1);
        check("R9 no store pulse", n_ok + n_err - k0, 0);
        check("R9 wr kept", wr_offset, 40);
        check("R9 marker kept", {mem[43], mem[42]}, 16'hFFF0);
    endtask

    task automatic t_host_ptr();
        write_rdptr(16'd24);               // read offset 40
        check("R8 rdptr", rdptr_q, 24);
        check("R8 empty", buf_empty, 1);
    endtask

    task automatic t_busy_wrap();
        int ok0 = n_ok;
        send(30, 8'hA0, 5'b0, 3'b0, 40);
        check_record("R7 wrap", 40, 30, 8'hA0, 16'h0001);
        check("R7 tail at 0", mem[9], 8'(8'hA0 + 8'd29));
        check("R6 wr wrapped", wr_offset, 12);
        check("R10 ok wrap", n_ok - ok0, 1);
    endtask

    task automatic t_exact_fit();
        int o0 = n_ovf, e0 = n_err;
        send(21, 8'h20, 5'b0, 3'b0, -1);   // free 28: 29 > 28
        check("R9 one byte over", n_ovf - o0, 1);
        check("R9 wr kept over", wr_offset, 12);
        send(20, 8'h30, 5'b00100, 3'b0, -1); // exactly 28
        check_record("R9 exact", 12, 20, 8'h30, 16'h0008);
        check("R9 wr exact", wr_offset, 36);
        check("R10 err exact", n_err - e0, 1);
    endtask

    task automatic t_single();
        int o0 = n_ovf;
        send(1, 8'h55, 5'b0, 3'b100, -1);  // free 4 < 9
        check("R9 single dropped", n_ovf - o0, 1);
        write_rdptr(16'd20);               // read offset 36
        check("R8 empty again", buf_empty, 1);
        send(1, 8'h55, 5'b0, 3'b100, -1);
        check_record("R11 single", 36, 1, 8'h55, 16'h8001);
        check("R11 wr", wr_offset, 44);
    endtask

    task automatic t_size();
        do_reset(2'd3);
        check("R6 reset large", wr_offset, 0);
        send(100, 8'h01, 5'b0, 3'b0, -1);
        check("R6 wr 104", wr_offset, 104);
        send(61, 8'h90, 5'b11000, 3'b0, -1);
        check_record("R6 large", 104, 61, 8'h90, exp_status(5'b11000, 3'b0));
        check("R6 wr 172", wr_offset, 172);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    endtask

    initial begin
        t_reset();
        t_good_frame();
        t_err_frame();
        t_overflow();
        t_host_ptr();
        t_busy_wrap();
        t_exact_fit();
        t_single();
        t_size();
        finished = 1;
        summary();
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            summary();
        end
    end

endmodule